// File: doc/BRIEF.md
# Multi-Axis Strided Layout Mapper

This block takes one logical tensor element and turns it into the physical coordinates that hold it. Each coordinate is a tuple with one value per hardware axis: memory slot, lane, warp and device. Software configures it with four shard iterators, two replica iterators and one constant offset per axis. Each iterator carries an extent, a stride and a target axis.

For each accepted element, the block does the following:
- It flattens the coordinate row-major against the supplied shape.
- It splits the flat index into one component per shard iterator, using an iterative divider.
- It scales each component by its stride and adds it onto the iterator's axis.
- It adds the per-axis offset.
- It steps through every replica combination and emits one tuple per handshake. The final tuple carries a last flag.

A shape whose element count differs from the product of the shard extents is rejected with a one-cycle error flag. Unused shard iterators are given extent 1 and stride 0. Unused replica iterators are given extent 1. Unused shape dimensions are given size 1.

Top module: `lm_layout_mapper`

## Requirements
- R1: Dimension 0 of the coordinate and shape occupies the lowest slice and is the outermost. The flat index is the row-major sum of each coordinate times the product of all later shape sizes. Shard component k equals floor(flat / product of the extents of shard iterators k+1..3) mod extent k, where iterator 0 sits in the lowest slice. Each component times its stride is added to the axis named by the iterator's axis code. Axis codes are 0 = memory (the default), 1 = lane, 2 = warp and 3 = device. Output axis a occupies slice a, and values wrap modulo 2^COORD_W.
- R2: When several shard iterators name the same axis, their contributions add together. For example, with extents 8,2,4,2, strides 4,1,1,1, axes lane,warp,lane,memory and shape (8,16), element (7,15) gives lane 31 and memory 1. Element (0,2) gives lane 1.
- R3: The configured per-axis offset is added to every emitted tuple.
- R4: The tuples are emitted one per accepted output handshake. There is one tuple for each replica combination, with replica 0 stepping fastest. Each replica adds its index times its stride to its axis. The last flag is set on the final tuple only. After the final tuple the input side is ready again. In the R2 example, with offset 5 on warp and a replica of extent 2 and stride 4 on warp, element (7,15) yields warp 6 and then warp 10.
- R5: With every replica extent equal to 1, exactly one tuple is emitted, with the last flag set. For example, extents 2,128,112,1, strides 112,1,1,0, axes memory,lane,memory,memory and shape (2,128,112) map element (1,127,111) to lane 127, memory 223.
- R6: An accepted element whose shape product differs from the product of the shard extents raises err_o during the next cycle only. No tuple is emitted for it, and the input stays ready.
- R7: in_ready_o is high only when the block is idle. A tuple offered while out_ready_i is low stays valid and unchanged.
- R8: A configuration load takes effect only while the block is idle. A load pulse during a sequence changes neither that element's tuples nor later ones.
- R9: After reset, in_ready_o is 1, and out_valid_o and err_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_load_i | input | 1 | Capture the configuration inputs (taken only when idle) |
| cfg_sh_ext_i | input | NUM_SHARD*IDX_W | Shard extents, iterator k in slice k |
| cfg_sh_stride_i | input | NUM_SHARD*IDX_W | Shard strides |
| cfg_sh_axis_i | input | NUM_SHARD*log2(NUM_AXES) | Shard target axis codes |
| cfg_rep_ext_i | input | NUM_REP*IDX_W | Replica extents |
| cfg_rep_stride_i | input | NUM_REP*IDX_W | Replica strides |
| cfg_rep_axis_i | input | NUM_REP*log2(NUM_AXES) | Replica target axis codes |
| cfg_offset_i | input | NUM_AXES*COORD_W | Constant per-axis offset |
| in_valid_i | input | 1 | Logical element offered |
| in_ready_o | output | 1 | Block idle and able to accept |
| in_coord_i | input | DIMS*IDX_W | Logical coordinate |
| in_shape_i | input | DIMS*IDX_W | Logical shape |
| err_o | output | 1 | Shape not admitted by the configured shard extents |
| out_valid_o | output | 1 | Physical tuple valid |
| out_ready_i | input | 1 | Consumer takes the tuple |
| out_coord_o | output | NUM_AXES*COORD_W | Physical coordinate, one slice per axis |
| out_last_o | output | 1 | Final tuple of the element |

## Verification
A wrong divider remainder or a wrong quotient hand-off between shard iterators corrupts one axis value of every tuple of the affected element. This shows on out_coord_o at the first tuple, about a hundred cycles after acceptance.

A broken replica counter is also caught. It shows as a wrong tuple order, a missing or extra tuple, or a misplaced out_last_o, all visible within that element's burst.

Configuration captured at the wrong time is detected through the next element's coordinates, after the load. Stalled outputs are sampled on consecutive cycles so that a changing tuple is caught.

// File: rtl/lm_pkg.sv
package lm_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_DIV, ST_EMIT} lm_state_e;
  localparam int AXIS_MEM = 0;
endpackage

// File: rtl/lm_div.sv
// Serial restoring divider, one quotient bit per cycle.
module lm_div #(
  parameter int NUM_W = 24,
  parameter int DEN_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [NUM_W-1:0] num_i,
  input  logic [DEN_W-1:0] den_i,
  output logic             done_o,
  output logic [NUM_W-1:0] quot_o,
  output logic [DEN_W-1:0] rem_o
);
  localparam int CW = (NUM_W > 1) ? $clog2(NUM_W) : 1;

  logic [DEN_W:0]   rem_q, rem_sh, rem_n;
  logic [NUM_W-1:0] quo_q;
  logic [CW-1:0]    cnt_q;
  logic             busy_q, done_q, ge;

  always_comb begin
    rem_sh = {rem_q[DEN_W-1:0], quo_q[NUM_W-1]};
    ge     = rem_sh >= {1'b0, den_i};
    rem_n  = ge ? rem_sh - {1'b0, den_i} : rem_sh;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q <= '0; quo_q <= '0; cnt_q <= '0; busy_q <= 1'b0; done_q <= 1'b0;
    end else if (start_i) begin
      rem_q <= '0; quo_q <= num_i; cnt_q <= '0; busy_q <= 1'b1; done_q <= 1'b0;
    end else if (busy_q) begin
      rem_q <= rem_n;
      quo_q <= {quo_q[NUM_W-2:0], ge};
      if (cnt_q == CW'(NUM_W-1)) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else begin
      done_q <= 1'b0;
    end
  end

  assign done_o = done_q;
  assign quot_o = quo_q;
  assign rem_o  = rem_q[DEN_W-1:0];
endmodule

// File: rtl/lm_rep_gen.sv
// Replica odometer: iterator 0 steps fastest; per-axis offset sum.
module lm_rep_gen #(
  parameter int NUM_REP  = 2,
  parameter int NUM_AXES = 4,
  parameter int IDX_W    = 8,
  parameter int COORD_W  = 16
) (
  input  logic                                 clk_i,
  input  logic                                 rst_ni,
  input  logic                                 clear_i,
  input  logic                                 step_i,
  input  logic [NUM_REP*IDX_W-1:0]             ext_i,
  input  logic [NUM_REP*IDX_W-1:0]             stride_i,
  input  logic [NUM_REP*$clog2(NUM_AXES)-1:0]  axis_i,
  output logic [NUM_AXES*COORD_W-1:0]          off_o,
  output logic                                 last_o
);
  localparam int AX_W = $clog2(NUM_AXES);
  localparam int PW   = 2 * IDX_W;

  logic [IDX_W-1:0] cnt_q [NUM_REP];
  logic [IDX_W-1:0] cnt_n [NUM_REP];
  logic [NUM_REP-1:0] at_max;

  for (genvar t = 0; t < NUM_REP; t++) begin : g_max
    assign at_max[t] = (ext_i[t*IDX_W +: IDX_W] <= IDX_W'(1)) ||
                       (cnt_q[t] == ext_i[t*IDX_W +: IDX_W] - 1'b1);
  end
  assign last_o = &at_max;

  always_comb begin
    logic carry;
    carry = 1'b1;
    for (int t = 0; t < NUM_REP; t++) begin
      cnt_n[t] = cnt_q[t];
      if (carry) begin
        if (at_max[t]) cnt_n[t] = '0;
        else begin
          cnt_n[t] = cnt_q[t] + 1'b1;
          carry    = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int t = 0; t < NUM_REP; t++) cnt_q[t] <= '0;
    end else if (clear_i) begin
      for (int t = 0; t < NUM_REP; t++) cnt_q[t] <= '0;
    end else if (step_i) begin
      for (int t = 0; t < NUM_REP; t++) cnt_q[t] <= cnt_n[t];
    end
  end

  always_comb begin
    logic [PW-1:0] p;
    off_o = '0;
    for (int a = 0; a < NUM_AXES; a++) begin
      for (int t = 0; t < NUM_REP; t++) begin
        p = PW'(cnt_q[t]) * PW'(stride_i[t*IDX_W +: IDX_W]);
        if (axis_i[t*AX_W +: AX_W] == AX_W'(a))
          off_o[a*COORD_W +: COORD_W] = off_o[a*COORD_W +: COORD_W] + COORD_W'(p);
      end
    end
  end
endmodule

// File: rtl/lm_layout_mapper.sv
module lm_layout_mapper
  import lm_pkg::*;
#(
  parameter int IDX_W     = 8,
  parameter int DIMS      = 3,
  parameter int NUM_SHARD = 4,
  parameter int NUM_REP   = 2,
  parameter int NUM_AXES  = 4,
  parameter int COORD_W   = 16
) (
  input  logic                                  clk_i,
  input  logic                                  rst_ni,
  input  logic                                  cfg_load_i,
  input  logic [NUM_SHARD*IDX_W-1:0]            cfg_sh_ext_i,
  input  logic [NUM_SHARD*IDX_W-1:0]            cfg_sh_stride_i,
  input  logic [NUM_SHARD*$clog2(NUM_AXES)-1:0] cfg_sh_axis_i,
  input  logic [NUM_REP*IDX_W-1:0]              cfg_rep_ext_i,
  input  logic [NUM_REP*IDX_W-1:0]              cfg_rep_stride_i,
  input  logic [NUM_REP*$clog2(NUM_AXES)-1:0]   cfg_rep_axis_i,
  input  logic [NUM_AXES*COORD_W-1:0]           cfg_offset_i,
  input  logic                                  in_valid_i,
  output logic                                  in_ready_o,
  input  logic [DIMS*IDX_W-1:0]                 in_coord_i,
  input  logic [DIMS*IDX_W-1:0]                 in_shape_i,
  output logic                                  err_o,
  output logic                                  out_valid_o,
  input  logic                                  out_ready_i,
  output logic [NUM_AXES*COORD_W-1:0]           out_coord_o,
  output logic                                  out_last_o
);
  localparam int AX_W   = $clog2(NUM_AXES);
  localparam int FLAT_W = DIMS * IDX_W;
  localparam int EP_W   = NUM_SHARD * IDX_W;
  localparam int CMP_W  = (FLAT_W > EP_W) ? FLAT_W : EP_W;
  localparam int KW     = (NUM_SHARD > 1) ? $clog2(NUM_SHARD) : 1;
  localparam int PW     = 2 * IDX_W;

  lm_state_e state_q;

  logic [NUM_SHARD*IDX_W-1:0] sh_ext_q, sh_str_q;
  logic [NUM_SHARD*AX_W-1:0]  sh_ax_q;
  logic [NUM_REP*IDX_W-1:0]   rp_ext_q, rp_str_q;
  logic [NUM_REP*AX_W-1:0]    rp_ax_q;
  logic [NUM_AXES*COORD_W-1:0] off_q;

  logic [FLAT_W-1:0]  num_q;
  logic [KW-1:0]      k_q;
  logic               go_q, err_q;
  logic [COORD_W-1:0] base_q [NUM_AXES];

  logic [FLAT_W-1:0]  flat;
  logic [CMP_W-1:0]   shp_prod, ext_prod;
  logic               admit, accept, fire;

  logic               div_done;
  logic [FLAT_W-1:0]  div_quot;
  logic [IDX_W-1:0]   div_rem, div_den, cur_str;
  logic [AX_W-1:0]    cur_ax;
  logic [PW-1:0]      contrib;

  logic [NUM_AXES*COORD_W-1:0] rep_off;
  logic                        rep_last;

  // Configuration capture, idle only
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_ext_q <= '0; sh_str_q <= '0; sh_ax_q <= '0;
      rp_ext_q <= '0; rp_str_q <= '0; rp_ax_q <= '0; off_q <= '0;
    end else if (cfg_load_i && state_q == ST_IDLE) begin
      sh_ext_q <= cfg_sh_ext_i;  sh_str_q <= cfg_sh_stride_i; sh_ax_q <= cfg_sh_axis_i;
      rp_ext_q <= cfg_rep_ext_i; rp_str_q <= cfg_rep_stride_i; rp_ax_q <= cfg_rep_axis_i;
      off_q    <= cfg_offset_i;
    end
  end

  // Row-major flatten and admitted-shape test
  always_comb begin
    flat     = '0;
    shp_prod = CMP_W'(1);
    ext_prod = CMP_W'(1);
    for (int d = 0; d < DIMS; d++) begin
      flat     = flat * FLAT_W'(in_shape_i[d*IDX_W +: IDX_W]) + FLAT_W'(in_coord_i[d*IDX_W +: IDX_W]);
      shp_prod = shp_prod * CMP_W'(in_shape_i[d*IDX_W +: IDX_W]);
    end
    for (int k = 0; k < NUM_SHARD; k++)
      ext_prod = ext_prod * CMP_W'(sh_ext_q[k*IDX_W +: IDX_W]);
  end
  assign admit = (shp_prod == ext_prod);

  assign in_ready_o = (state_q == ST_IDLE);
  assign accept     = in_valid_i && in_ready_o;
  assign fire       = out_valid_o && out_ready_i;

  assign div_den = sh_ext_q[k_q*IDX_W +: IDX_W];
  assign cur_str = sh_str_q[k_q*IDX_W +: IDX_W];
  assign cur_ax  = sh_ax_q[k_q*AX_W +: AX_W];
  assign contrib = PW'(div_rem) * PW'(cur_str);

  lm_div #(.NUM_W(FLAT_W), .DEN_W(IDX_W)) u_div (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (go_q),
    .num_i   (num_q),
    .den_i   (div_den),
    .done_o  (div_done),
    .quot_o  (div_quot),
    .rem_o   (div_rem)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      num_q   <= '0;
      k_q     <= '0;
      go_q    <= 1'b0;
      err_q   <= 1'b0;
      for (int a = 0; a < NUM_AXES; a++) base_q[a] <= '0;
    end else begin
      go_q  <= 1'b0;
      err_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (accept) begin
          if (admit) begin
            state_q <= ST_DIV;
            num_q   <= flat;
            k_q     <= KW'(NUM_SHARD-1);
            go_q    <= 1'b1;
            for (int a = 0; a < NUM_AXES; a++) base_q[a] <= off_q[a*COORD_W +: COORD_W];
          end else begin
            err_q <= 1'b1;
          end
        end
        // Innermost iterator first: remainder is the component, quotient feeds the next
        ST_DIV: if (div_done) begin
          for (int a = 0; a < NUM_AXES; a++)
            if (cur_ax == AX_W'(a)) base_q[a] <= base_q[a] + COORD_W'(contrib);
          num_q <= div_quot;
          if (k_q == '0) state_q <= ST_EMIT;
          else begin
            k_q  <= k_q - 1'b1;
            go_q <= 1'b1;
          end
        end
        ST_EMIT: if (fire && rep_last) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  lm_rep_gen #(
    .NUM_REP(NUM_REP), .NUM_AXES(NUM_AXES), .IDX_W(IDX_W), .COORD_W(COORD_W)
  ) u_rep (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (accept),
    .step_i   (fire),
    .ext_i    (rp_ext_q),
    .stride_i (rp_str_q),
    .axis_i   (rp_ax_q),
    .off_o    (rep_off),
    .last_o   (rep_last)
  );

  for (genvar a = 0; a < NUM_AXES; a++) begin : g_out
    assign out_coord_o[a*COORD_W +: COORD_W] = base_q[a] + rep_off[a*COORD_W +: COORD_W];
  end

  assign out_valid_o = (state_q == ST_EMIT);
  assign out_last_o  = out_valid_o && rep_last;
  assign err_o       = err_q;
endmodule

// File: rtl/lm_layout_mapper_chk.sv
module lm_layout_mapper_chk #(
  parameter int NUM_AXES = 4,
  parameter int COORD_W  = 16
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic                        in_valid_i,
  input logic                        in_ready_o,
  input logic                        err_o,
  input logic                        out_valid_o,
  input logic                        out_ready_i,
  input logic [NUM_AXES*COORD_W-1:0] out_coord_o,
  input logic                        out_last_o
);
  AST_READY_IDLE_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_ready_o |-> !out_valid_o); // R7
  AST_HOLD_ON_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_coord_o) && $stable(out_last_o)); // R7
  AST_ERR_NO_OUTPUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !out_valid_o && in_ready_o); // R6
  AST_ERR_FROM_REQUEST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(in_valid_i && in_ready_o)); // R6
  AST_LAST_RETURNS_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_ready_i && out_last_o |=> in_ready_o); // R4
  AST_BURST_CONTINUES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_ready_i && !out_last_o |=> out_valid_o); // R4
endmodule

bind lm_layout_mapper lm_layout_mapper_chk #(.NUM_AXES(NUM_AXES), .COORD_W(COORD_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .in_ready_o  (in_ready_o),
  .err_o       (err_o),
  .out_valid_o (out_valid_o),
  .out_ready_i (out_ready_i),
  .out_coord_o (out_coord_o),
  .out_last_o  (out_last_o)
);

// File: tb/sim_lm_layout_mapper.sv
module sim_lm_layout_mapper;
  localparam int CLK_PERIOD = 10;
  localparam int IW = 8, NS = 4, NR = 2, NA = 4, CW = 16, DM = 3, AW = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_load = 1'b0, in_valid = 1'b0, out_ready = 1'b0;
  logic [NS*IW-1:0] sh_ext = '0, sh_str = '0;
  logic [NS*AW-1:0] sh_ax = '0;
  logic [NR*IW-1:0] rp_ext = '0, rp_str = '0;
  logic [NR*AW-1:0] rp_ax = '0;
  logic [NA*CW-1:0] offs = '0;
  logic [DM*IW-1:0] coord = '0, shape = '0;
  logic in_ready, err, out_valid, out_last;
  logic [NA*CW-1:0] out_coord;

  int n_checks = 0, n_fail = 0;
  int se[NS], ss[NS], sa[NS], re[NR], rs[NR], ra[NR], of[NA];
  int cx[DM], cs[DM];

  always #(CLK_PERIOD/2) clk = ~clk;

  lm_layout_mapper u0 (
    .clk_i(clk), .rst_ni(rst_n), .cfg_load_i(cfg_load),
    .cfg_sh_ext_i(sh_ext), .cfg_sh_stride_i(sh_str), .cfg_sh_axis_i(sh_ax),
    .cfg_rep_ext_i(rp_ext), .cfg_rep_stride_i(rp_str), .cfg_rep_axis_i(rp_ax),
    .cfg_offset_i(offs), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .in_coord_i(coord), .in_shape_i(shape), .err_o(err),
    .out_valid_o(out_valid), .out_ready_i(out_ready),
    .out_coord_o(out_coord), .out_last_o(out_last)
  );

  task automatic chk(input string req, input int got, input int exp);
    n_checks++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  function automatic int exp_axis(input int a, input int n);
    int flat, v, div, c, rr, r;
    flat = (cx[0] * cs[1] + cx[1]) * cs[2] + cx[2];
    v = of[a];
    for (int k = 0; k < NS; k++) begin
      div = 1;
      for (int l = k + 1; l < NS; l++) div *= se[l];
      c = (flat / div) % se[k];
      if (sa[k] == a) v += c * ss[k];
    end
    rr = n;
    for (int t = 0; t < NR; t++) begin
      r = rr % re[t];
      rr = rr / re[t];
      if (ra[t] == a) v += r * rs[t];
    end
    return v & 16'hFFFF;
  endfunction

  task automatic pack_cfg();
    for (int k = 0; k < NS; k++) begin
      sh_ext[k*IW +: IW] = IW'(se[k]); sh_str[k*IW +: IW] = IW'(ss[k]); sh_ax[k*AW +: AW] = AW'(sa[k]);
    end
    for (int t = 0; t < NR; t++) begin
      rp_ext[t*IW +: IW] = IW'(re[t]); rp_str[t*IW +: IW] = IW'(rs[t]); rp_ax[t*AW +: AW] = AW'(ra[t]);
    end
    for (int a = 0; a < NA; a++) offs[a*CW +: CW] = CW'(of[a]);
  endtask

  task automatic load_cfg();
    @(negedge clk);
    pack_cfg();
    cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
  endtask

  task automatic do_elem(input int x0, x1, x2, s0, s1, s2, input bit stall_en);
    int nrep, eprod;
    logic [NA*CW-1:0] held;
    cx[0] = x0; cx[1] = x1; cx[2] = x2; cs[0] = s0; cs[1] = s1; cs[2] = s2;
    eprod = 1;
    for (int k = 0; k < NS; k++) eprod *= se[k];
    nrep = re[0] * re[1];
    @(negedge clk);
    chk("R7 ready when idle", int'(in_ready), 1);
    for (int d = 0; d < DM; d++) begin
      coord[d*IW +: IW] = IW'(cx[d]); shape[d*IW +: IW] = IW'(cs[d]);
    end
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    if (s0 * s1 * s2 != eprod) begin
      chk("R6 err flag", int'(err), 1);
      chk("R6 no output", int'(out_valid), 0);
      chk("R6 still ready", int'(in_ready), 1);
      @(negedge clk);
      chk("R6 err one cycle", int'(err), 0);
      repeat (3) begin
        @(negedge clk);
        chk("R6 no output later", int'(out_valid), 0);
      end
      return;
    end
    chk("R7 not ready while busy", int'(in_ready), 0);
    for (int n = 0; n < nrep; n++) begin
      out_ready = 1'b0;
      while (!out_valid) @(negedge clk);
      if (stall_en && ($urandom % 2 == 0)) begin
        held = out_coord;
        repeat (1 + $urandom % 3) begin
          @(negedge clk);
          chk("R7 stall hold valid", int'(out_valid), 1);
          chk("R7 stall hold coord", int'(out_coord == held), 1);
        end
      end
      for (int a = 0; a < NA; a++)
        chk($sformatf("R1 R2 R3 R4 axis %0d rep %0d", a, n), int'(out_coord[a*CW +: CW]), exp_axis(a, n));
      chk("R4 last flag", int'(out_last), int'(n == nrep - 1));
      out_ready = 1'b1;
      @(negedge clk);
    end
    out_ready = 1'b0;
    chk("R4 idle after last", int'(in_ready), 1);
    chk("R4 no extra tuple", int'(out_valid), 0);
  endtask

  task automatic cfg_tile();
    se = '{8, 2, 4, 2}; ss = '{4, 1, 1, 1}; sa = '{1, 2, 1, 0};
    re = '{2, 1}; rs = '{4, 0}; ra = '{2, 0}; of = '{0, 0, 5, 0};
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1357));
    repeat (3) @(negedge clk);
    chk("R9 reset ready", int'(in_ready), 1);
    chk("R9 reset valid", int'(out_valid), 0);
    chk("R9 reset err", int'(err), 0);
    rst_n = 1'b1;

    // Tile vector with replica on warp
    cfg_tile();
    load_cfg();
    do_elem(7, 15, 0, 8, 16, 1, 1'b0);
    do_elem(0, 2, 0, 8, 16, 1, 1'b1);
    do_elem(0, 0, 0, 8, 16, 1, 1'b1);
    do_elem(1, 0, 0, 8, 16, 1, 1'b0);
    do_elem(0, 8, 0, 8, 16, 1, 1'b0);
    // Literal spot check for R2: element (7,15), first tuple
    cx = '{7, 15, 0}; cs = '{8, 16, 1};
    chk("R2 lane literal", exp_axis(1, 0), 31);
    chk("R4 warp literal", exp_axis(2, 1), 10);

    // Rejected shape
    do_elem(0, 0, 0, 8, 15, 1, 1'b0);

    // Pure placement, no replica
    se = '{2, 128, 112, 1}; ss = '{112, 1, 1, 0}; sa = '{0, 1, 0, 0};
    re = '{1, 1}; rs = '{0, 0}; ra = '{0, 0}; of = '{0, 0, 0, 0};
    load_cfg();
    do_elem(1, 127, 111, 2, 128, 112, 1'b0);
    chk("R5 lane literal", exp_axis(1, 0), 127);
    chk("R5 col literal", exp_axis(0, 0), 223);
    do_elem(0, 5, 3, 2, 128, 112, 1'b1);

    // Load pulse mid-sequence must be ignored
    cfg_tile();
    load_cfg();
    fork
      do_elem(7, 15, 0, 8, 16, 1, 1'b0);
      begin
        repeat (6) @(negedge clk);
        offs = {16'd100, 16'd200, 16'd300, 16'd400};
        rp_ext = '0;
        sh_str = {4{8'd9}};
        cfg_load = 1'b1;
        @(negedge clk);
        cfg_load = 1'b0;
      end
    join
    do_elem(3, 9, 0, 8, 16, 1, 1'b0); // R8 later element keeps old config

    // Random configurations
    for (int it = 0; it < 120; it++) begin
      int s[3], mode;
      if (it % 8 == 0) begin
        for (int k = 0; k < NS; k++) begin
          se[k] = 1 + $urandom % 6; ss[k] = $urandom % 21; sa[k] = $urandom % NA;
        end
        for (int t = 0; t < NR; t++) begin
          re[t] = 1 + $urandom % 3; rs[t] = $urandom % 51; ra[t] = $urandom % NA;
        end
        for (int a = 0; a < NA; a++) of[a] = $urandom % 1000;
        load_cfg();
      end
      mode = $urandom % 3;
      if (mode == 0) s = '{se[0] * se[1], se[2], se[3]};
      else if (mode == 1) s = '{se[0], se[1] * se[2], se[3]};
      else s = '{1, se[0] * se[1] * se[2], se[3]};
      if ($urandom % 10 == 0) s[2] = s[2] + 1;
      do_elem($urandom % s[0], $urandom % s[1], $urandom % s[2], s[0], s[1], s[2], 1'b1);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule